// File: doc/BRIEF.md
# Narrow-Bus CAM Command Sequencer

This block turns host lookup requests into command sequences for a content-addressable memory. That memory has no separate result bus and no free-entry bus. All data goes over one half-width data path, and the memory can drive it as well as receive it. A host word of twice the path width is therefore sent as two beats. Each beat asserts the word-enable line of the register half it targets. Search results and the lowest-empty-entry pointer come back the same way: the sequencer issues register-read commands and reassembles the two returned halves into one host response.

The host side is a valid/ready request that carries an operation, an address and a full-width payload, plus a response strobe with full-width data. The sequencer runs one request at a time. It keeps ready low until the whole CAM-side sequence, including the result read, has finished. As a result, no search can start while a read owns the data path, and responses return in request order.

All memory-side outputs are registered. The data path changes direction only across at least one idle cycle, in which nobody drives it.

Top module: `narrow_cam_seq`

## Requirements
- R1: While and just after reset, reqReady is 1, rspValid is 0, camCmd is NOP (0), camWe is 0 and camDqOe is 0.
- R2: Every driven beat asserts exactly one word enable. camWe = 2'b01 carries word bits [35:0], and camWe = 2'b10 carries word bits [71:36]. A register read uses the same encoding to pick the half the memory returns.
- R3: A write or search loads the comparand as LOAD (code 1) low half, then LOAD high half, in consecutive cycles. The next cycle carries WRITE (code 2) with camAddr equal to the request address, or SEARCH (code 3).
- R4: After SEARCH, the next two cycles issue register-read (code 4) to register 1 (the result register), low half then high half. The response is {high, low}. rspValid rises 7 clock edges after the accepting edge, counting that edge.
- R5: Operation 2 reads register reqAddr[1:0] (0 comparand, 1 result, 2 lowest empty entry), low half then high half. Its response rises 4 edges after acceptance, counting the accepting edge.
- R6: The sequencer never drives in a cycle when the memory drives. The memory drives in the cycle after a register-read command. The sequencer also leaves the path idle for at least the cycle after that.
- R7: reqReady is 0 from acceptance until the sequence ends, and a request held valid meanwhile is not taken. Back-to-back searches are accepted exactly 7 cycles apart; writes and register reads are accepted 4 cycles apart.
- R8: Exactly one response is produced per accepted request, in acceptance order. A write returns all-zero data, 4 edges after acceptance counting the accepting edge.
- R9: Operation 3 is accepted and sends no command to the memory. Its all-zero response appears in the cycle right after the accepting edge.
- R10: camDqOe is 1 only in LOAD cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Sequencer idle, request taken on this edge |
| reqOp | input | 2 | 0 write, 1 search, 2 register read, 3 no-op |
| reqAddr | input | ADDR_W | Entry address (write) or register id (read) |
| reqData | input | 2*HALF_W | Entry data or search key |
| rspValid | output | 1 | One-cycle response strobe |
| rspData | output | 2*HALF_W | Response word |
| camCmd | output | 3 | Memory command code |
| camWe | output | 2 | Half-word enables |
| camAddr | output | ADDR_W | Memory address / register id |
| camDqOut | output | HALF_W | Data driven toward the memory |
| camDqOe | output | 1 | Sequencer drives the data path |
| camDqIn | input | HALF_W | Data path value as seen by the sequencer |

## Verification
The assertions assume the memory answers a register-read command by driving in the very next cycle and not in any other cycle, and that reset is held low for several clocks at start-up. The bench's behavioural memory follows exactly that registered timing. It fills the data path with a fixed junk pattern whenever it is not driving, so a capture in the wrong cycle shows up in the response. The host driver holds reqValid high, with the next payload, during busy periods. It never drives the bus itself, so every drive-enable seen on the path comes from the sequencer.

// File: rtl/cam_seq_pkg.sv
package cam_seq_pkg;

  typedef enum logic [1:0] {
    OP_WRITE  = 2'd0,
    OP_SEARCH = 2'd1,
    OP_RDREG  = 2'd2,
    OP_NOP    = 2'd3
  } hostOp_e;

  typedef enum logic [2:0] {
    CMD_NOP    = 3'd0,
    CMD_LOAD   = 3'd1,
    CMD_WRITE  = 3'd2,
    CMD_SEARCH = 3'd3,
    CMD_RDREG  = 3'd4
  } camCmd_e;

  localparam int unsigned REG_RESULT = 1;

  // Control-to-datapath strobes. The pin fields describe the next cycle's
  // memory-side outputs; the others act on the current edge.
  typedef struct packed {
    camCmd_e    pinCmd;
    logic [1:0] pinWe;
    logic       pinDrive;
    logic       pinHigh;
    logic       pinResultAddr;
    logic       take;
    logic       capLow;
    logic       rspFire;
    logic       rspZero;
  } seqStrobe_t;

endpackage

// File: rtl/cam_seq_ctrl.sv
module cam_seq_ctrl
  import cam_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  output logic       reqReady,
  output seqStrobe_t strobe
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_LDLO, ST_LDHI, ST_EXEC, ST_RDLO, ST_RDHI, ST_CAP
  } seqState_e;

  seqState_e state, stateNxt;
  hostOp_e   opQ, opNxt;
  hostOp_e   reqOpE;
  logic      accept;

  assign reqOpE   = hostOp_e'(reqOp);
  assign reqReady = (state == ST_IDLE);
  assign accept   = reqReady && reqValid;

  always_comb begin
    stateNxt = state;
    opNxt    = opQ;
    case (state)
      ST_IDLE: begin
        if (accept) begin
          opNxt = reqOpE;
          case (reqOpE)
            OP_WRITE, OP_SEARCH: stateNxt = ST_LDLO;
            OP_RDREG:            stateNxt = ST_RDLO;
            default:             stateNxt = ST_IDLE;
          endcase
        end
      end
      ST_LDLO: stateNxt = ST_LDHI;
      ST_LDHI: stateNxt = ST_EXEC;
      ST_EXEC: stateNxt = (opQ == OP_SEARCH) ? ST_RDLO : ST_IDLE;
      ST_RDLO: stateNxt = ST_RDHI;
      ST_RDHI: stateNxt = ST_CAP;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      opQ   <= OP_NOP;
    end else begin
      state <= stateNxt;
      opQ   <= opNxt;
    end
  end

  // Pin fields are decoded from the next state so that the registered
  // memory-side outputs line up with the state they belong to.
  always_comb begin
    strobe        = '0;
    strobe.pinCmd = CMD_NOP;
    case (stateNxt)
      ST_LDLO: begin
        strobe.pinCmd   = CMD_LOAD;
        strobe.pinWe    = 2'b01;
        strobe.pinDrive = 1'b1;
      end
      ST_LDHI: begin
        strobe.pinCmd   = CMD_LOAD;
        strobe.pinWe    = 2'b10;
        strobe.pinDrive = 1'b1;
        strobe.pinHigh  = 1'b1;
      end
      ST_EXEC: strobe.pinCmd = (opNxt == OP_SEARCH) ? CMD_SEARCH : CMD_WRITE;
      ST_RDLO: begin
        strobe.pinCmd        = CMD_RDREG;
        strobe.pinWe         = 2'b01;
        strobe.pinResultAddr = (opNxt == OP_SEARCH);
      end
      ST_RDHI: begin
        strobe.pinCmd        = CMD_RDREG;
        strobe.pinWe         = 2'b10;
        strobe.pinResultAddr = (opNxt == OP_SEARCH);
      end
      default: ;
    endcase
    strobe.take    = accept;
    strobe.capLow  = (state == ST_RDHI);
    strobe.rspFire = (state == ST_CAP)
                   || (state == ST_EXEC && opQ == OP_WRITE)
                   || (accept && reqOpE == OP_NOP);
    strobe.rspZero = strobe.rspFire && (state != ST_CAP);
  end

endmodule

// File: rtl/cam_seq_dp.sv
module cam_seq_dp
  import cam_seq_pkg::*;
#(
  parameter  int HALF_W = 36,
  parameter  int ADDR_W = 8,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [WORD_W-1:0] reqData,
  input  logic [HALF_W-1:0] camDqIn,
  output logic [2:0]        camCmd,
  output logic [1:0]        camWe,
  output logic [ADDR_W-1:0] camAddr,
  output logic [HALF_W-1:0] camDqOut,
  output logic              camDqOe,
  output logic              rspValid,
  output logic [WORD_W-1:0] rspData
);

  logic [WORD_W-1:0] wordQ, wordNow;
  logic [ADDR_W-1:0] addrQ, addrNow;
  logic [HALF_W-1:0] lowQ, halfSel;

  // On the accepting edge the request itself feeds the first beat.
  assign wordNow = strobe.take ? reqData : wordQ;
  assign addrNow = strobe.take ? reqAddr : addrQ;
  assign halfSel = strobe.pinHigh ? wordNow[WORD_W-1:HALF_W] : wordNow[HALF_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordQ    <= '0;
      addrQ    <= '0;
      lowQ     <= '0;
      camCmd   <= CMD_NOP;
      camWe    <= '0;
      camAddr  <= '0;
      camDqOut <= '0;
      camDqOe  <= 1'b0;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      wordQ    <= wordNow;
      addrQ    <= addrNow;
      camCmd   <= strobe.pinCmd;
      camWe    <= strobe.pinWe;
      camDqOe  <= strobe.pinDrive;
      camDqOut <= strobe.pinDrive ? halfSel : '0;
      camAddr  <= strobe.pinResultAddr ? ADDR_W'(REG_RESULT) : addrNow;
      if (strobe.capLow) lowQ <= camDqIn;
      rspValid <= strobe.rspFire;
      if (strobe.rspFire) rspData <= strobe.rspZero ? '0 : {camDqIn, lowQ};
    end
  end

endmodule

// File: rtl/narrow_cam_seq.sv
module narrow_cam_seq
  import cam_seq_pkg::*;
#(
  parameter  int HALF_W = 36,
  parameter  int ADDR_W = 8,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [WORD_W-1:0] reqData,
  output logic              rspValid,
  output logic [WORD_W-1:0] rspData,
  output logic [2:0]        camCmd,
  output logic [1:0]        camWe,
  output logic [ADDR_W-1:0] camAddr,
  output logic [HALF_W-1:0] camDqOut,
  output logic              camDqOe,
  input  logic [HALF_W-1:0] camDqIn
);

  seqStrobe_t strobe;

  cam_seq_ctrl ctrlI (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqReady(reqReady), .strobe(strobe)
  );

  cam_seq_dp #(.HALF_W(HALF_W), .ADDR_W(ADDR_W)) dpI (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .reqData(reqData), .camDqIn(camDqIn), .camCmd(camCmd), .camWe(camWe),
    .camAddr(camAddr), .camDqOut(camDqOut), .camDqOe(camDqOe),
    .rspValid(rspValid), .rspData(rspData)
  );

endmodule

// File: rtl/cam_seq_chk.sv
module cam_seq_chk
  import cam_seq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic [2:0]        camCmd,
  input logic [1:0]        camWe,
  input logic [ADDR_W-1:0] camAddr,
  input logic              camDqOe
);

  a_r2_single_half: assert property (@(posedge clk) disable iff (!rstN)
    camDqOe |-> (camWe == 2'b01 || camWe == 2'b10));

  a_r3_low_then_high: assert property (@(posedge clk) disable iff (!rstN)
    (camCmd == CMD_LOAD && camWe == 2'b01) |=> (camCmd == CMD_LOAD && camWe == 2'b10));

  a_r3_high_after_low: assert property (@(posedge clk) disable iff (!rstN)
    (camCmd == CMD_LOAD && camWe == 2'b10) |-> $past(camCmd == CMD_LOAD && camWe == 2'b01));

  a_r4_result_read: assert property (@(posedge clk) disable iff (!rstN)
    (camCmd == CMD_SEARCH) |=>
      (camCmd == CMD_RDREG && camWe == 2'b01 && camAddr == ADDR_W'(REG_RESULT)));

  a_r6_no_contention: assert property (@(posedge clk) disable iff (!rstN)
    (camCmd == CMD_RDREG) |=> !camDqOe);

  a_r6_turnaround: assert property (@(posedge clk) disable iff (!rstN)
    (camCmd == CMD_RDREG) |=> ##1 !camDqOe);

  a_r7_busy_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    (camCmd != CMD_NOP) |-> !reqReady);

  a_r10_drive_load_only: assert property (@(posedge clk) disable iff (!rstN)
    camDqOe |-> (camCmd == CMD_LOAD));

endmodule

bind narrow_cam_seq cam_seq_chk #(.ADDR_W(ADDR_W)) chkI (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .camCmd(camCmd),
  .camWe(camWe), .camAddr(camAddr), .camDqOe(camDqOe)
);

// File: tb/narrow_cam_seq_tb_top.sv
module narrow_cam_seq_tb_top;
  import cam_seq_pkg::*;

  localparam int HW = 36;
  localparam int WW = 2 * HW;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [1:0]    reqOp = 2'd3;
  logic [AW-1:0] reqAddr = '0;
  logic [WW-1:0] reqData = '0;
  logic          rspValid;
  logic [WW-1:0] rspData;
  logic [2:0]    camCmd;
  logic [1:0]    camWe;
  logic [AW-1:0] camAddr;
  logic [HW-1:0] camDqOut;
  logic          camDqOe;
  logic [HW-1:0] camDqIn;

  narrow_cam_seq #(.HALF_W(HW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqData(reqData),
    .rspValid(rspValid), .rspData(rspData), .camCmd(camCmd), .camWe(camWe),
    .camAddr(camAddr), .camDqOut(camDqOut), .camDqOe(camDqOe), .camDqIn(camDqIn)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural memory on the data path ----------------
  logic [WW-1:0] mEnt [DEPTH];
  logic [DEPTH-1:0] mVal = '0;
  logic [WW-1:0] mCmp = '0, mRes = '0;
  logic          mDrv = 1'b0;
  logic [HW-1:0] mRd = '0;
  assign camDqIn = mDrv ? mRd : {9{4'hA}};

  function automatic logic [WW-1:0] searchIn(input logic [WW-1:0] key,
                                             input bit useRef);
    logic [WW-1:0] r = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (useRef ? (rVal[i] && rEnt[i] == key) : (mVal[i] && mEnt[i] == key)) begin
        r = '0;
        r[AW] = 1'b1;
        r[AW-1:0] = AW'(i);
      end
    end
    return r;
  endfunction

  function automatic logic [WW-1:0] freeIn(input bit useRef);
    logic [WW-1:0] r = '0;
    r[AW] = 1'b1;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!(useRef ? rVal[i] : mVal[i])) begin
        r = '0;
        r[AW-1:0] = AW'(i);
      end
    end
    return r;
  endfunction

  always @(posedge clk) begin
    logic [WW-1:0] v;
    mDrv <= 1'b0;
    if (rstN) begin
      case (camCmd)
        3'd1: begin
          if (camWe[0]) mCmp[HW-1:0] <= camDqOut;
          if (camWe[1]) mCmp[WW-1:HW] <= camDqOut;
        end
        3'd2: begin
          mEnt[camAddr] <= mCmp;
          mVal[camAddr] <= 1'b1;
        end
        3'd3: mRes <= searchIn(mCmp, 1'b0);
        3'd4: begin
          case (camAddr[1:0])
            2'd0: v = mCmp;
            2'd1: v = mRes;
            2'd2: v = freeIn(1'b0);
            default: v = '0;
          endcase
          mDrv <= 1'b1;
          mRd  <= camWe[1] ? v[WW-1:HW] : v[HW-1:0];
        end
        default: ;
      endcase
    end
  end

  // ---------------- reference model and scoreboard ----------------
  logic [WW-1:0] rEnt [DEPTH];
  logic [DEPTH-1:0] rVal = '0;
  logic [WW-1:0] rCmp = '0, rRes = '0;

  logic [WW-1:0] expData[$];
  int            expCyc[$];
  string         expTag[$];

  task automatic send(input logic [1:0] op, input logic [AW-1:0] addr,
                      input logic [WW-1:0] data, input string tag,
                      output int tAcc);
    logic [WW-1:0] e = '0;
    int lat;
    reqValid = 1'b1;
    reqOp = op;
    reqAddr = addr;
    reqData = data;
    while (!reqReady) @(negedge clk);
    tAcc = cyc;
    case (op)
      2'd0: begin rEnt[addr] = data; rVal[addr] = 1'b1; lat = 4; end
      2'd1: begin rCmp = data; rRes = searchIn(data, 1'b1); e = rRes; lat = 7; end
      2'd2: begin
        case (addr[1:0])
          2'd0: e = rCmp;
          2'd1: e = rRes;
          2'd2: e = freeIn(1'b1);
          default: e = '0;
        endcase
        lat = 4;
      end
      default: lat = 1;
    endcase
    expData.push_back(e);
    expCyc.push_back(tAcc + lat);
    expTag.push_back(tag);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // ---------------- monitor ----------------
  bit lastDrv = 1'b0;
  bit lastLoLo = 1'b0;
  bit lastLoHi = 1'b0;

  always @(negedge clk) begin
    if (rstN && !done) begin
      if (rspValid) begin
        if (expData.size() == 0) begin
          chk(1'b0, "R8", "unexpected response", rspData, '0);
        end else begin
          chk(rspData == expData[0], expTag[0], "response data", rspData, expData[0]);
          chk(cyc == expCyc[0], expTag[0], "response cycle", WW'(cyc), WW'(expCyc[0]));
          void'(expData.pop_front());
          void'(expCyc.pop_front());
          void'(expTag.pop_front());
        end
      end
      if (mDrv) chk(!camDqOe, "R6", "drive while memory drives", WW'(camDqOe), '0);
      if (lastDrv) chk(!camDqOe, "R6", "drive in turnaround cycle", WW'(camDqOe), '0);
      if (camDqOe) begin
        chk(camCmd == 3'd1, "R10", "drive outside LOAD", WW'(camCmd), WW'(1));
        chk(camWe == 2'b01 || camWe == 2'b10, "R2", "word enable", WW'(camWe), WW'(1));
      end
      if (lastLoLo) chk(camCmd == 3'd1 && camWe == 2'b10, "R3", "high beat after low",
                        WW'({camCmd, camWe}), WW'({3'd1, 2'b10}));
      if (lastLoHi) chk(camCmd == 3'd2 || camCmd == 3'd3, "R3", "command after load",
                        WW'(camCmd), WW'(2));
      if (camCmd == 3'd1 && camWe == 2'b10)
        chk(lastLoLo, "R3", "high beat without low", '0, WW'(1));
      lastDrv  = mDrv;
      lastLoLo = (camCmd == 3'd1 && camWe == 2'b01);
      lastLoHi = (camCmd == 3'd1 && camWe == 2'b10);
    end
  end

  // write address is checked when the model stores the entry
  always @(negedge clk) begin
    if (rstN && !done && camCmd == 3'd2)
      chk(camAddr == reqAddrHold, "R3", "write address", WW'(camAddr), WW'(reqAddrHold));
  end
  logic [AW-1:0] reqAddrHold = '0;
  always @(posedge clk) if (reqValid && reqReady) reqAddrHold <= reqAddr;

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", "run did not finish", '0, '0);
    done = 1'b1;
    summary();
    $finish;
  end

  localparam logic [WW-1:0] KEY_A = 72'h12_3456_789A_BCDE_F012;
  localparam logic [WW-1:0] KEY_B = 72'hFE_DCBA_9876_5432_10FE;
  localparam logic [WW-1:0] KEY_C = 72'h00_0000_000F_FFFF_FFFF;

  initial begin
    int t0, t1, t2, t3;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk(reqReady == 1'b1, "R1", "ready in reset", WW'(reqReady), WW'(1));
    chk(rspValid == 1'b0, "R1", "rspValid in reset", WW'(rspValid), '0);
    chk(camCmd == 3'd0 && camWe == 2'b00 && camDqOe == 1'b0, "R1", "pins in reset",
        WW'({camCmd, camWe, camDqOe}), '0);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady && !rspValid && camCmd == 3'd0 && !camDqOe, "R1", "after reset",
        WW'({reqReady, rspValid, camCmd, camDqOe}), WW'(6'b100000));

    // R5 empty table: lowest empty entry is 0
    send(2'd2, 8'd2, '0, "R5", t0);
    // R8 writes, zero responses, entries at 5, 9, 3
    send(2'd0, 8'd5, KEY_A, "R8", t0);
    send(2'd0, 8'd9, KEY_B, "R8", t1);
    chk(t1 - t0 == 4, "R7", "write spacing", WW'(t1 - t0), WW'(4));
    send(2'd0, 8'd3, KEY_A, "R8", t0);
    // R4 searches: lowest matching index wins, a miss, a low-half-only key
    send(2'd1, '0, KEY_A, "R4", t0);
    chk(reqReady == 1'b0, "R7", "ready low while busy", WW'(reqReady), '0);
    send(2'd1, '0, KEY_B, "R4", t1);
    chk(t1 - t0 == 7, "R7", "search spacing", WW'(t1 - t0), WW'(7));
    send(2'd1, '0, KEY_C, "R4", t2);
    send(2'd1, '0, KEY_A, "R4", t3);
    chk(t3 - t2 == 7, "R7", "search spacing", WW'(t3 - t2), WW'(7));
    // R2 comparand readback proves the halves landed in the right place
    send(2'd2, 8'd0, '0, "R2", t0);
    send(2'd2, 8'd1, '0, "R5", t0);
    send(2'd2, 8'd2, '0, "R5", t0);
    // R9 no-op: no command, immediate zero response
    send(2'd3, 8'd7, KEY_B, "R9", t0);
    chk(camCmd == 3'd0 && !camDqOe, "R9", "no command for no-op",
        WW'({camCmd, camDqOe}), '0);
    // R6 direction changes both ways
    send(2'd0, 8'd0, KEY_C, "R8", t0);
    send(2'd2, 8'd2, '0, "R6", t1);
    send(2'd0, 8'd1, KEY_B, "R6", t2);
    chk(t2 - t1 == 4, "R7", "read spacing", WW'(t2 - t1), WW'(4));
    send(2'd1, '0, KEY_C, "R4", t0);
    send(2'd2, 8'd2, '0, "R5", t0);

    for (int i = 0; i < 50 && expData.size() != 0; i++) @(negedge clk);
    chk(expData.size() == 0, "R8", "responses outstanding", WW'(expData.size()), '0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule